// File: doc/BRIEF.md
# Five-Stage Pipeline Interlock Unit

This block is the stall controller of an in-order processor pipeline with five stages: fetch, address computation, operand fetch, operate and operand store. Instructions arrive already decoded, one per accepted transfer, as a small record. The record holds a tag, a destination/source register number `r`, an index register number `x`, an effective address, and flags. The flags say whether the instruction reads register `r` at operand fetch, reads memory at operand fetch, or uses `x` for indexing during address computation. They also say whether it will write register `r` or memory. The unit carries each record through five interstage slots. Results are written only in the store stage, and operands are read only in the operand fetch stage.

Two hazard checks run every cycle on the current slot contents. The operand-fetch check matches the operand fetch stage's register number or address against pending writes in the operate and store stages. It freezes fetch, address computation and operand fetch, and empties the operate slot. The index check matches the address-computation stage's index register against pending register writes in operand fetch, operate and store. It freezes only fetch and address computation, and empties the operand fetch slot. The operate stage's write flags are early predictions. No value is forwarded, so a dependent reader waits until the cycle after the producer's store stage.

Input follows valid/ready: a record is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` drops while either interlock is active, and the source must then hold its record stable until it is taken. The output side is the store-stage slot. It has no back-pressure: the store stage advances every cycle.

Top module: `pil_top`

## Requirements
- R1: After synchronous active-high reset all five slots are empty: `out_valid` is 0, `in_ready` is 1 and both stall outputs are 0.
- R2: With no hazards, one record is taken per cycle and records leave the store stage on consecutive cycles.
- R3: A record reading register `r` at operand fetch is held there while the operate slot predicts a write to the same `r`, or the store slot writes it. A dependent reader placed directly after its producer leaves 3 cycles after it (two bubbles). With one independent record between them the gap is 2 (one bubble). With two between, no bubble appears.
- R4: The same hold applies when a record reads memory at operand fetch and the operate or store slot writes the same effective address. Different addresses cause no stall.
- R5: A record using index register `x` at address computation is held while operand fetch, operate or store holds a pending write to register `x`. Only fetch and address computation freeze. An empty slot enters operand fetch, and older records keep moving. A user placed directly after its producer leaves 4 cycles after it.
- R6: During an operand-fetch interlock (`stall_of`=1) fetch, address computation and operand fetch keep their contents, the operate slot receives an empty entry, and `in_ready` is 0.
- R7: When both interlocks are active in one cycle, the operand-fetch interlock wins: three stages freeze and the empty entry goes to operate.
- R8: An empty slot never counts as a reader or writer. Flags presented with `in_valid`=0 have no effect on later timing.
- R9: Records leave the store stage in the order they were taken, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Offered record is valid |
| in_ready | output | 1 | Unit takes the record on this edge |
| in_tag | input | TAG_W | Record identifier |
| in_r | input | RN_W | Register field r (source at operand fetch, or destination) |
| in_x | input | RN_W | Index register field |
| in_ea | input | EA_W | Effective address |
| in_rd_reg | input | 1 | Reads register r at operand fetch |
| in_rd_mem | input | 1 | Reads memory at operand fetch |
| in_use_idx | input | 1 | Uses register x at address computation |
| in_wr_reg | input | 1 | Will write register r in the store stage |
| in_wr_mem | input | 1 | Will write memory in the store stage |
| out_valid | output | 1 | Store-stage slot holds a record |
| out_tag | output | TAG_W | Tag of the store-stage record |
| out_r | output | RN_W | Register field of the store-stage record |
| out_ea | output | EA_W | Address of the store-stage record |
| out_wr_reg | output | 1 | Register write performed this cycle |
| out_wr_mem | output | 1 | Memory write performed this cycle |
| stall_of | output | 1 | Operand-fetch interlock active |
| stall_ac | output | 1 | Index interlock active (may coincide with stall_of) |

## Verification
The bench measures the cycle gap between successive retirements while the source streams records without pause. Gaps beyond one are therefore bubbles inserted by the interlocks. Load/store pairs with zero, one and two fillers separate the two- and one-bubble cases from the no-stall case. A memory-address pair, alone and with non-matching addresses, separates real address matches from false ones. An index-register pair with a gap of four shows that only two stages freeze. A combined case where the register and index hazards occur together tells the correct priority apart from the reversed one. An idle input slot carrying write flags shows whether empty entries leak into the hazard logic.

// File: rtl/pil_pkg.sv
package pil_pkg;
  localparam int TAG_W = 8;
  localparam int RN_W  = 4;
  localparam int EA_W  = 12;

  localparam int N_STG = 5;
  localparam int ST_IF = 0;
  localparam int ST_AC = 1;
  localparam int ST_OF = 2;
  localparam int ST_OP = 3;
  localparam int ST_OS = 4;

  // number of frozen stages for each interlock = index of the bubble slot
  localparam int FRZ_OF = ST_OP;
  localparam int FRZ_AC = ST_OF;

  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] tag;
    logic [RN_W-1:0]  r;
    logic [RN_W-1:0]  x;
    logic [EA_W-1:0]  ea;
    logic             rd_reg;
    logic             rd_mem;
    logic             use_idx;
    logic             wr_reg;
    logic             wr_mem;
  } slot_t;
endpackage

// File: rtl/pil_stage.sv
module pil_stage
  import pil_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  hold,
  input  logic  kill,
  input  slot_t d,
  output slot_t q
);
  // empty entries are stored as all-zero so they never carry flags
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (!hold) begin
      if (kill)       q <= '0;
      else if (d.vld) q <= d;
      else            q <= '0;
    end
  end
endmodule

// File: rtl/pil_hazard.sv
module pil_hazard
  import pil_pkg::*;
(
  input  logic            ac_use_idx,
  input  logic [RN_W-1:0] ac_x,
  input  logic            of_vld,
  input  logic            of_rd_reg,
  input  logic            of_rd_mem,
  input  logic            of_wr_reg,
  input  logic [RN_W-1:0] of_r,
  input  logic [EA_W-1:0] of_ea,
  input  logic            op_wr_reg,
  input  logic            op_wr_mem,
  input  logic [RN_W-1:0] op_r,
  input  logic [EA_W-1:0] op_ea,
  input  logic            os_wr_reg,
  input  logic            os_wr_mem,
  input  logic [RN_W-1:0] os_r,
  input  logic [EA_W-1:0] os_ea,
  output logic            of_lock,
  output logic            ac_lock
);
  logic reg_vs_op, reg_vs_os, mem_vs_op, mem_vs_os;
  logic idx_vs_of, idx_vs_op, idx_vs_os;

  always_comb begin
    reg_vs_op = of_rd_reg && op_wr_reg && (of_r == op_r);
    reg_vs_os = of_rd_reg && os_wr_reg && (of_r == os_r);
    mem_vs_op = of_rd_mem && op_wr_mem && (of_ea == op_ea);
    mem_vs_os = of_rd_mem && os_wr_mem && (of_ea == os_ea);
    of_lock   = of_vld && (reg_vs_op || reg_vs_os || mem_vs_op || mem_vs_os);

    idx_vs_of = of_wr_reg && (ac_x == of_r);
    idx_vs_op = op_wr_reg && (ac_x == op_r);
    idx_vs_os = os_wr_reg && (ac_x == os_r);
    ac_lock   = ac_use_idx && (idx_vs_of || idx_vs_op || idx_vs_os);
  end
endmodule

// File: rtl/pil_top.sv
module pil_top
  import pil_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [RN_W-1:0]  in_r,
  input  logic [RN_W-1:0]  in_x,
  input  logic [EA_W-1:0]  in_ea,
  input  logic             in_rd_reg,
  input  logic             in_rd_mem,
  input  logic             in_use_idx,
  input  logic             in_wr_reg,
  input  logic             in_wr_mem,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag,
  output logic [RN_W-1:0]  out_r,
  output logic [EA_W-1:0]  out_ea,
  output logic             out_wr_reg,
  output logic             out_wr_mem,
  output logic             stall_of,
  output logic             stall_ac
);
  slot_t            stg_d [N_STG];
  slot_t            stg_q [N_STG];
  logic [N_STG-1:0] hold_v;
  logic [N_STG-1:0] kill_v;
  int unsigned      frz;

  pil_hazard u_haz (
    .ac_use_idx (stg_q[ST_AC].use_idx),
    .ac_x       (stg_q[ST_AC].x),
    .of_vld     (stg_q[ST_OF].vld),
    .of_rd_reg  (stg_q[ST_OF].rd_reg),
    .of_rd_mem  (stg_q[ST_OF].rd_mem),
    .of_wr_reg  (stg_q[ST_OF].wr_reg),
    .of_r       (stg_q[ST_OF].r),
    .of_ea      (stg_q[ST_OF].ea),
    .op_wr_reg  (stg_q[ST_OP].wr_reg),
    .op_wr_mem  (stg_q[ST_OP].wr_mem),
    .op_r       (stg_q[ST_OP].r),
    .op_ea      (stg_q[ST_OP].ea),
    .os_wr_reg  (stg_q[ST_OS].wr_reg),
    .os_wr_mem  (stg_q[ST_OS].wr_mem),
    .os_r       (stg_q[ST_OS].r),
    .os_ea      (stg_q[ST_OS].ea),
    .of_lock    (stall_of),
    .ac_lock    (stall_ac)
  );

  // operand-fetch interlock has priority over the index interlock
  always_comb begin
    if (stall_of)      frz = FRZ_OF;
    else if (stall_ac) frz = FRZ_AC;
    else               frz = 0;
  end

  assign in_ready = !(stall_of || stall_ac);

  always_comb begin
    stg_d[ST_IF]         = '0;
    stg_d[ST_IF].vld     = in_valid;
    stg_d[ST_IF].tag     = in_tag;
    stg_d[ST_IF].r       = in_r;
    stg_d[ST_IF].x       = in_x;
    stg_d[ST_IF].ea      = in_ea;
    stg_d[ST_IF].rd_reg  = in_rd_reg;
    stg_d[ST_IF].rd_mem  = in_rd_mem;
    stg_d[ST_IF].use_idx = in_use_idx;
    stg_d[ST_IF].wr_reg  = in_wr_reg;
    stg_d[ST_IF].wr_mem  = in_wr_mem;
  end

  for (genvar gi = 0; gi < N_STG; gi++) begin : g_stage
    if (gi > 0) begin : g_link
      assign stg_d[gi] = stg_q[gi-1];
    end
    assign hold_v[gi] = (gi < frz);
    assign kill_v[gi] = (frz != 0) && (gi == frz);

    pil_stage u_stg (
      .clk  (clk),
      .rst  (rst),
      .hold (hold_v[gi]),
      .kill (kill_v[gi]),
      .d    (stg_d[gi]),
      .q    (stg_q[gi])
    );
  end

  assign out_valid  = stg_q[ST_OS].vld;
  assign out_tag    = stg_q[ST_OS].tag;
  assign out_r      = stg_q[ST_OS].r;
  assign out_ea     = stg_q[ST_OS].ea;
  assign out_wr_reg = stg_q[ST_OS].wr_reg;
  assign out_wr_mem = stg_q[ST_OS].wr_mem;

  logic unused_fields;
  assign unused_fields = &{1'b0, stg_q[ST_OS].x, stg_q[ST_OS].rd_reg,
                           stg_q[ST_OS].rd_mem, stg_q[ST_OS].use_idx,
                           stg_q[ST_OF].wr_mem};

  // R1: reset empties the pipe
  p_rst_empty_r1: assert property (@(posedge clk) rst |=> !out_valid);

  // R2: the store stage is never frozen
  p_os_advance_r2: assert property (@(posedge clk) disable iff (rst)
    stg_q[ST_OP].vld |=> out_valid);

  // R6: operand-fetch interlock empties operate and holds operand fetch
  p_op_bubble_r6: assert property (@(posedge clk) disable iff (rst)
    stall_of |=> !stg_q[ST_OP].vld);
  p_of_hold_r6: assert property (@(posedge clk) disable iff (rst)
    stall_of |=> $stable(stg_q[ST_OF]));

  // R5: index interlock alone empties operand fetch, holds address computation
  p_of_bubble_r5: assert property (@(posedge clk) disable iff (rst)
    (stall_ac && !stall_of) |=> !stg_q[ST_OF].vld);
  p_ac_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (stall_ac || stall_of) |=> $stable(stg_q[ST_AC]));

  // R8: an empty operate slot announces no write
  p_empty_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !stg_q[ST_OP].vld |-> !(stg_q[ST_OP].wr_reg || stg_q[ST_OP].wr_mem));
endmodule

// File: tb/pil_top_tb_top.sv
`timescale 1ns/1ps
module pil_top_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        in_valid = 0;
  logic        in_ready;
  logic [7:0]  in_tag = 0;
  logic [3:0]  in_r = 0, in_x = 0;
  logic [11:0] in_ea = 0;
  logic        in_rd_reg = 0, in_rd_mem = 0, in_use_idx = 0;
  logic        in_wr_reg = 0, in_wr_mem = 0;
  logic        out_valid;
  logic [7:0]  out_tag;
  logic [3:0]  out_r;
  logic [11:0] out_ea;
  logic        out_wr_reg, out_wr_mem, stall_of, stall_ac;

  always #2.5 clk = ~clk;

  pil_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_r(in_r), .in_x(in_x), .in_ea(in_ea),
    .in_rd_reg(in_rd_reg), .in_rd_mem(in_rd_mem), .in_use_idx(in_use_idx),
    .in_wr_reg(in_wr_reg), .in_wr_mem(in_wr_mem),
    .out_valid(out_valid), .out_tag(out_tag), .out_r(out_r), .out_ea(out_ea),
    .out_wr_reg(out_wr_reg), .out_wr_mem(out_wr_mem),
    .stall_of(stall_of), .stall_ac(stall_ac)
  );

  typedef struct {
    logic [7:0] tag;
    int         gap;   // 0 = first of a sequence, gap not checked
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc = 0;
  int   last_cyc = 0;
  bit   done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: offer one record, push the expected retirement
  task automatic send(input logic [7:0] tg, input logic [3:0] r, input logic [3:0] x,
                      input logic [11:0] ea, input bit rr, input bit rm, input bit ui,
                      input bit wr, input bit wm, input int gap, input string req);
    @(negedge clk);
    in_valid = 1; in_tag = tg; in_r = r; in_x = x; in_ea = ea;
    in_rd_reg = rr; in_rd_mem = rm; in_use_idx = ui; in_wr_reg = wr; in_wr_mem = wm;
    exp_q.push_back('{tg, gap, req});
    while (!in_ready) @(negedge clk);
  endtask

  // idle slots carry junk write flags that must be ignored (R8)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_tag = 8'hEE; in_r = 4'd3; in_x = 4'd3; in_ea = 12'h0AA;
      in_rd_reg = 0; in_rd_mem = 0; in_use_idx = 0; in_wr_reg = 1; in_wr_mem = 1;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R9", "unexpected retirement tag", out_tag, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(out_tag == e.tag, e.req, "retired tag", out_tag, e.tag);
        if (e.gap != 0)
          check(cyc - last_cyc == e.gap, e.req,
                $sformatf("gap before tag %0d", e.tag), cyc - last_cyc, e.gap);
      end
      last_cyc = cyc;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
    check(stall_of == 0, "R1", "stall_of after reset", stall_of, 0);
    check(stall_ac == 0, "R1", "stall_ac after reset", stall_ac, 0);

    // R2 / R9: independent stream, one per cycle in order
    send(1, 1, 0, 12'h001, 0, 0, 0, 1, 0, 0, "R2");
    send(2, 2, 0, 12'h002, 0, 0, 0, 1, 0, 1, "R2");
    send(3, 3, 0, 12'h003, 1, 0, 0, 0, 0, 1, "R2");
    send(4, 4, 0, 12'h004, 0, 1, 0, 0, 0, 1, "R9");
    send(5, 5, 0, 12'h005, 0, 0, 0, 0, 1, 1, "R9");
    idle(10);

    // R3 / R6: load r1 then store r1 adjacent -> two bubbles
    send(10, 1, 0, 12'h100, 0, 1, 0, 1, 0, 0, "R3");
    send(11, 1, 0, 12'h101, 1, 0, 0, 0, 1, 3, "R6");
    idle(10);

    // R3: one filler -> one bubble
    send(20, 1, 0, 12'h100, 0, 1, 0, 1, 0, 0, "R3");
    send(21, 7, 0, 12'h200, 0, 0, 0, 0, 0, 1, "R3");
    send(22, 1, 0, 12'h101, 1, 0, 0, 0, 1, 2, "R3");
    idle(10);

    // R3: two fillers -> no bubble
    send(30, 1, 0, 12'h100, 0, 1, 0, 1, 0, 0, "R3");
    send(31, 7, 0, 12'h200, 0, 0, 0, 0, 0, 1, "R3");
    send(32, 8, 0, 12'h201, 0, 0, 0, 0, 0, 1, "R3");
    send(33, 1, 0, 12'h101, 1, 0, 0, 0, 1, 1, "R3");
    idle(10);

    // R4: memory address hazard, then non-matching addresses
    send(40, 5, 0, 12'h055, 1, 0, 0, 0, 1, 0, "R4");
    send(41, 2, 0, 12'h055, 0, 1, 0, 1, 0, 3, "R4");
    send(42, 6, 0, 12'h010, 0, 0, 0, 0, 1, 1, "R4");
    send(43, 9, 0, 12'h011, 0, 1, 0, 1, 0, 1, "R4");
    idle(10);

    // R5: index register hazard, older record unaffected
    send(49, 9, 0, 12'h300, 0, 0, 0, 0, 0, 0, "R5");
    send(50, 2, 0, 12'h301, 0, 1, 0, 1, 0, 1, "R5");
    send(51, 6, 2, 12'h302, 0, 0, 1, 0, 0, 4, "R5");
    idle(10);

    // R8: idle slot with junk write flags causes no stall
    send(60, 9, 0, 12'h400, 0, 0, 0, 0, 0, 0, "R8");
    idle(1);
    send(61, 3, 3, 12'h0AA, 1, 1, 1, 0, 0, 2, "R8");
    idle(10);

    // R7: both interlocks in the same cycle
    send(70, 1, 0, 12'h500, 0, 1, 0, 1, 0, 0, "R7");
    send(71, 1, 0, 12'h501, 1, 0, 0, 0, 1, 3, "R7");
    send(72, 4, 1, 12'h502, 0, 0, 1, 0, 0, 1, "R7");
    idle(12);

    check(exp_q.size() == 0, "R9", "records never retired", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule